// File: doc/BRIEF.md
# Multichannel PWM Capture Unit

This block measures the high time and the low time of many pulse-width-modulated inputs in parallel. Every channel is sampled in the same clock domain by one shared pipeline. Each raw pin passes through a synchronizer and a debouncer. Edges are found by comparing the filtered level with its value one cycle earlier. A running counter per channel measures how long the level has held. When a level ends, its length is stored as that channel's high-time or low-time result.

A one-cycle pulse on `snapshot_req` freezes the results of all channels at the same clock edge. The frozen words then leave over a valid/ready stream in a fixed order. A channel whose input has not toggled for a long time is flagged as stuck, together with the level it is stuck at. The stuck and level flags travel in a status word at the end of each snapshot. A request that arrives while a snapshot is still streaming is dropped, and this is reported later through an overflow bit.

Top module: `pwmcap_top`

## Requirements
- R1: After reset, `out_valid` is 0, and every high-time and low-time result reads 0 in the first snapshot.
- R2: For each channel, the high result is the number of clock cycles the input was high between a rising edge and the next falling edge. The low result is the number of cycles from a falling edge to the next rising edge. All channels are measured at the same time.
- R3: The half-period that ends at the first edge after reset is not recorded. A result stays 0 until a level that started at an edge has completed.
- R4: An input pulse shorter than `DEBOUNCE_CYCLES` cycles causes no edge and changes no result.
- R5: When a channel sees no edge for `TIMEOUT_CYCLES` cycles, three things happen. Its stuck bit is set. Its level bit takes the held level. Both of its results become all ones. The next edge clears the stuck bit.
- R6: The running counter saturates at all ones instead of wrapping. A level held longer than the counter range is therefore recorded as all ones.
- R7: A snapshot begins only in response to `snapshot_req`. It emits these words in order:
  - channel 0 high
  - channel 0 low
  - channel 1 high, and so on for every channel
  - last, a status word
- R7 (status word layout): bit c is channel c's stuck flag. Bit `NUM_CH`+c is channel c's stuck level, which is 0 when the channel is not stuck. The MSB is the overflow flag.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R9: A `snapshot_req` that arrives while a snapshot is streaming is dropped. The words being streamed are not disturbed, and the overflow flag is set. The overflow flag appears in the status word of the next snapshot that is taken, and is then cleared.
- R10: Every snapshot delivers exactly 2*`NUM_CH`+1 words before `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | NUM_CH | Raw PWM inputs, asynchronous to `clk` |
| snapshot_req | input | 1 | One-cycle pulse that freezes all results |
| out_valid | output | 1 | A stream word is present |
| out_ready | input | 1 | The consumer accepts the word this cycle |
| out_data | output | CNT_W | Stream word: a result or the status word |

## Verification
The bench drives every channel with its own periodic pattern and sweeps the high and low lengths over six combinations. Because the channels use distinct lengths, a result delivered in the wrong stream slot, or a high time swapped with a low time, is detected. These sweeps are read back under several backpressure patterns, which separates correct handshaking from skipped or repeated words. Single manual pulses on one channel test that the first half-period is discarded and that short glitches are filtered out. Long constant levels, one high and one low, test that stuck detection reports the right level and that the counters saturate. A second request issued during a stream tests that the snapshot is dropped and that the overflow flag is reported once and then cleared.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
    // Word slot of a channel's results inside a snapshot
    function automatic int high_slot(input int ch);
        return 2 * ch;
    endfunction
    function automatic int low_slot(input int ch);
        return 2 * ch + 1;
    endfunction
endpackage

// File: rtl/pwmcap_filter.sv
module pwmcap_filter #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_out
);
    localparam int DB_W = (DEBOUNCE_CYCLES < 2) ? 1 : $clog2(DEBOUNCE_CYCLES);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [DB_W-1:0]        cnt;
    } filt_t;

    filt_t q, d;
    logic  sampled;

    assign sampled = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_in};
        if (sampled != q.level) begin
            if (q.cnt == DB_W'(DEBOUNCE_CYCLES - 1)) begin
                d.level = sampled;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_out = q.level;
endmodule

// File: rtl/pwmcap_channel.sv
module pwmcap_channel #(
    parameter int CNT_W          = 32,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_in,
    output logic [CNT_W-1:0] high_time,
    output logic [CNT_W-1:0] low_time,
    output logic             stuck,
    output logic             stuck_level
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT_CYCLES);

    typedef struct packed {
        logic             prev;
        logic             seen;
        logic             stuck;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
    } chan_t;

    chan_t q, d;
    logic  edge_now;

    assign edge_now = level_in != q.prev;

    always_comb begin
        d      = q;
        d.prev = level_in;
        if (edge_now) begin
            d.run   = CNT_W'(1);
            d.seen  = 1'b1;
            d.stuck = 1'b0;
            if (q.seen) begin
                if (q.prev) d.high = q.run;
                else        d.low  = q.run;
            end
        end else begin
            if (q.run != CNT_MAX) d.run = q.run + 1'b1;
            if (q.run >= TO_LIM) begin
                d.stuck = 1'b1;
                d.high  = CNT_MAX;
                d.low   = CNT_MAX;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign high_time   = q.high;
    assign low_time    = q.low;
    assign stuck       = q.stuck;
    assign stuck_level = q.stuck & q.prev;
endmodule

// File: rtl/pwmcap_stream.sv
module pwmcap_stream #(
    parameter int NUM_CH = 13,
    parameter int CNT_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           snapshot_req,
    input  logic [2*NUM_CH-1:0][CNT_W-1:0] live_res,
    input  logic [NUM_CH-1:0]              live_stuck,
    input  logic [NUM_CH-1:0]              live_level,
    input  logic                           out_ready,
    output logic                           out_valid,
    output logic [CNT_W-1:0]               out_data
);
    localparam int NW    = 2 * NUM_CH + 1;
    localparam int IDX_W = $clog2(NW);

    typedef struct packed {
        logic                       busy;
        logic                       ovf;
        logic [IDX_W-1:0]           idx;
        logic [NW-1:0][CNT_W-1:0]   snap;
    } strm_t;

    strm_t q, d;
    logic  [CNT_W-1:0] status_word;

    always_comb begin
        status_word                     = '0;
        status_word[NUM_CH-1:0]         = live_stuck;
        status_word[2*NUM_CH-1:NUM_CH]  = live_level;
        status_word[CNT_W-1]            = q.ovf;
    end

    always_comb begin
        d = q;
        if (q.busy && out_ready) begin
            if (q.idx == IDX_W'(NW - 1)) d.busy = 1'b0;
            else                         d.idx  = q.idx + 1'b1;
        end
        if (snapshot_req) begin
            if (q.busy) begin
                d.ovf = 1'b1;
            end else begin
                d.busy = 1'b1;
                d.idx  = '0;
                d.ovf  = 1'b0;
                for (int w = 0; w < 2 * NUM_CH; w++) d.snap[w] = live_res[w];
                d.snap[NW-1] = status_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.busy;
    assign out_data  = q.snap[q.idx];
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top #(
    parameter int NUM_CH          = 13,
    parameter int CNT_W           = 32,
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 4,
    parameter int TIMEOUT_CYCLES  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic              snapshot_req,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  out_data
);
    import pwmcap_pkg::*;

    logic [2*NUM_CH-1:0][CNT_W-1:0] res;
    logic [NUM_CH-1:0]              stuck_v;
    logic [NUM_CH-1:0]              level_v;
    logic [NUM_CH-1:0]              filt_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmcap_filter #(
            .SYNC_STAGES    (SYNC_STAGES),
            .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pwm_in[c]),
            .level_out(filt_v[c])
        );
        pwmcap_channel #(
            .CNT_W         (CNT_W),
            .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_in   (filt_v[c]),
            .high_time  (res[high_slot(c)]),
            .low_time   (res[low_slot(c)]),
            .stuck      (stuck_v[c]),
            .stuck_level(level_v[c])
        );
    end

    pwmcap_stream #(
        .NUM_CH(NUM_CH),
        .CNT_W (CNT_W)
    ) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .snapshot_req(snapshot_req),
        .live_res    (res),
        .live_stuck  (stuck_v),
        .live_level  (level_v),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );
endmodule

// File: rtl/pwmcap_checker.sv
module pwmcap_checker #(
    parameter int NUM_CH = 13,
    parameter int CNT_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snapshot_req,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CNT_W-1:0] out_data
);
    localparam int NW  = 2 * NUM_CH + 1;
    localparam int CW  = $clog2(NW + 1) + 1;

    logic [CW-1:0] taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      taken <= '0;
        else if (!out_valid)             taken <= '0;
        else if (out_ready)              taken <= taken + 1'b1;
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (taken == CW'(NW)));

    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(snapshot_req));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !snapshot_req) |=> !out_valid);
endmodule

bind pwmcap_top pwmcap_checker #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
) u_pwmcap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .snapshot_req(snapshot_req),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data)
);

// File: tb/pwmcap_top_bench.sv
module pwmcap_top_bench;
    localparam int N   = 3;
    localparam int W   = 8;
    localparam int DB  = 3;
    localparam int TO  = 100;
    localparam int NW  = 2 * N + 1;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwm_bit [N];
    logic [N-1:0] pwm_in;
    logic         snapshot_req = 1'b0;
    logic         out_ready = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit per_en [N];
    int hi [N];
    int lo [N];
    logic [W-1:0] got [NW];
    logic [W-1:0] exp_w [NW];

    always #10 clk = ~clk;

    assign pwm_in = {pwm_bit[2], pwm_bit[1], pwm_bit[0]};

    pwmcap_top #(
        .NUM_CH(N), .CNT_W(W), .SYNC_STAGES(2),
        .DEBOUNCE_CYCLES(DB), .TIMEOUT_CYCLES(TO)
    ) u_pwmcap_top (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .snapshot_req(snapshot_req), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive(input int c);
        @(negedge clk);
        forever begin
            if (per_en[c]) begin
                pwm_bit[c] = 1'b1;
                repeat (hi[c]) @(negedge clk);
                pwm_bit[c] = 1'b0;
                repeat (lo[c]) @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Collect one snapshot; rmode 0 = always ready, else ready skips every (rmode+1)th cycle
    task automatic collect(input int rmode);
        int n = 0;
        int k = 0;
        while (n < NW && k < 500) begin
            out_ready = (rmode == 0) ? 1'b1 : ((k % (rmode + 1)) != 0);
            #1;
            if (out_valid && out_ready) begin
                got[n] = out_data;
                n++;
            end
            @(negedge clk);
            k++;
        end
        out_ready = 1'b0;
        if (n < NW) check("R10 words", W'(n), W'(NW));
    endtask

    task automatic take(input int rmode);
        snapshot_req = 1'b1;
        @(negedge clk);
        snapshot_req = 1'b0;
        collect(rmode);
    endtask

    task automatic compare(input string req);
        for (int w = 0; w < NW; w++) check(req, got[w], exp_w[w]);
    endtask

    task automatic set_pattern(input int p);
        for (int c = 0; c < N; c++) begin
            hi[c] = 3 + p + 2 * c;
            lo[c] = 4 + 2 * p + c;
            exp_w[2 * c]     = W'(hi[c]);
            exp_w[2 * c + 1] = W'(lo[c]);
        end
        exp_w[NW-1] = '0;
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            pwm_bit[c] = 1'b0;
            per_en[c] = 1'b0;
            hi[c] = 4;
            lo[c] = 4;
        end
        for (int c = 0; c < N; c++) begin
            automatic int cc = c;
            fork drive(cc); join_none
        end
        wait_cyc(5);
        rst_n = 1'b1;
        #1;
        check("R1 out_valid after reset", W'(out_valid), '0);
        wait_cyc(12);

        // R1/R3: no completed half-period yet
        take(0);
        for (int w = 0; w < NW; w++) exp_w[w] = '0;
        compare("R1 R3 reset results");

        // R3: a 6-cycle high pulse records high, initial low discarded
        pwm_bit[0] = 1'b1;
        wait_cyc(6);
        pwm_bit[0] = 1'b0;
        wait_cyc(12);
        take(0);
        exp_w[0] = W'(6);
        compare("R3 first half discarded");

        // R4: a 2-cycle glitch is filtered
        pwm_bit[0] = 1'b1;
        wait_cyc(2);
        pwm_bit[0] = 1'b0;
        wait_cyc(8);
        take(1);
        compare("R4 glitch ignored");

        // R2/R7/R8: sweep of patterns with backpressure
        for (int p = 0; p < 6; p++) begin
            set_pattern(p);
            for (int c = 0; c < N; c++) per_en[c] = 1'b1;
            wait_cyc(120);
            take(p % 3);
            compare("R2 R7 R8 sweep");
        end

        // R5/R6: ch1 stuck high, ch2 stuck low
        per_en[1] = 1'b0;
        per_en[2] = 1'b0;
        wait_cyc(40);
        pwm_bit[1] = 1'b1;
        pwm_bit[2] = 1'b0;
        wait_cyc(300);
        take(0);
        exp_w[2] = ALL1; exp_w[3] = ALL1;
        exp_w[4] = ALL1; exp_w[5] = ALL1;
        exp_w[NW-1] = W'(8'h16);
        compare("R5 stuck flags");

        pwm_bit[1] = 1'b0;
        wait_cyc(10);
        take(0);
        exp_w[NW-1] = W'(8'h04);
        compare("R6 R5 saturate and clear");

        // R9: overflow drop
        set_pattern(0);
        for (int c = 0; c < N; c++) per_en[c] = 1'b1;
        wait_cyc(120);
        out_ready = 1'b0;
        snapshot_req = 1'b1;
        @(negedge clk);
        snapshot_req = 1'b0;
        wait_cyc(3);
        snapshot_req = 1'b1;
        @(negedge clk);
        snapshot_req = 1'b0;
        wait_cyc(2);
        collect(0);
        compare("R9 first snapshot intact");
        take(0);
        exp_w[NW-1] = W'(8'h80);
        compare("R9 overflow reported");
        take(2);
        exp_w[NW-1] = '0;
        compare("R9 overflow cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule